// File: doc/BRIEF.md
# Bus Break Condition Comparator

This block sits beside a processor's bus and inspects every cycle the processor or a DMA engine performs. Each cycle presents an address, the program counter, a data word, an access size, a direction, a source tag and a cache-hit indication. Three independent condition channels compare those cycles against programmed settings. When a channel's condition is satisfied, it sets its own sticky match flag, and a shared break request is raised so that a debug controller can halt the processor.

The three channels are not equal. Channel 1 can compare address, data, direction and bus type, and it can also require a number of repeated hits before it fires. Channel 2 can compare address, direction, bus type and the address-space identifier, but it has no data or count comparison. Channel 2 also stays silent while a software-breakpoint instruction executes. Channel 3 only watches for two events: an access to internal I/O space and the execution of a TLB-load instruction.

Each field of each channel has its own enable bit. A channel fires only when every enabled field agrees within the same cycle. Configuration arrives on static input ports. Match flags are cleared by a per-channel clear strobe.

Top module: `brk_cond_top`

## Requirements
- R1: The address field compares `cfg` address against `cyc_addr` when the channel's PC-select bit is 0, or against `cyc_pc` when it is 1. It matches only on full equality.
- R2: The channel-1 data field compares only the byte lanes covered by the access size. Size code 0 is a byte (bits 7:0), code 1 is a word (bits 15:0), and code 2 is a longword (all 32 bits). When the size restriction is enabled, `cyc_size` must also equal the programmed size code.
- R3: The direction field uses `rw` code 01 for read only (`cyc_write`=0), 10 for write only, 11 for either direction, and 00 for never.
- R4: The bus-type field uses source tags 0 = CPU fetch, 1 = CPU data and 2 = DMA. Select code 0 accepts any CPU access (fetch or data, hit or miss). Code 1 accepts CPU data only. Code 2 accepts any access from source 0, 1 or 2 with `cyc_cache_hit` low.
- R5: A channel matches only when `cyc_valid` is high, at least one of its fields is enabled, and all of its enabled fields match in the same cycle.
- R6: With the channel-1 count enabled and limit N, where N=0 acts as 1, flag 0 sets on the Nth qualifying hit. The hit tally restarts after it fires and whenever `flag_clr[0]` is high.
- R7: The channel-2 ASID field matches on equality with `cyc_asid`. Channel 2 never matches in a cycle where `swbp_exec` is high.
- R8: Channel 3 has an internal-I/O enable and a TLB-load enable. Each enabled event must be present in the cycle, so with both enabled, both are required.
- R9: Match flags (bit 0 = channel 1, bit 1 = channel 2, bit 2 = channel 3) stay set until their `flag_clr` bit is high. A match in the same cycle as a clear leaves the flag set.
- R10: A match registered at clock edge k sets its flag at edge k and drives `brk_req` high for the cycle that follows edge k+1. `brk_req` is low after any cycle without a registered match.
- R11: After reset, `match_flag` is 0, `brk_req` is 0 and the channel-1 hit tally is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | A bus cycle is present |
| cyc_addr | input | 32 | Bus address |
| cyc_pc | input | 32 | Program counter of the cycle |
| cyc_data | input | 32 | Bus data |
| cyc_size | input | 2 | Access size code |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_src | input | 2 | Source tag |
| cyc_cache_hit | input | 1 | Access hit the cache |
| cyc_asid | input | 8 | Address-space identifier |
| cyc_io | input | 1 | Access targets internal I/O |
| cyc_tlbld | input | 1 | TLB-load instruction executes |
| swbp_exec | input | 1 | Software-breakpoint instruction executes |
| c1_addr_en | input | 1 | Ch1 address field enable |
| c1_use_pc | input | 1 | Ch1 compares PC instead of bus address |
| c1_addr | input | 32 | Ch1 address value |
| c1_data_en | input | 1 | Ch1 data field enable |
| c1_data | input | 32 | Ch1 data value |
| c1_size_en | input | 1 | Ch1 size restriction enable |
| c1_size | input | 2 | Ch1 size code |
| c1_rw_en | input | 1 | Ch1 direction field enable |
| c1_rw | input | 2 | Ch1 direction code |
| c1_bus_en | input | 1 | Ch1 bus-type field enable |
| c1_bus | input | 2 | Ch1 bus-type select |
| c1_cnt_en | input | 1 | Ch1 count enable |
| c1_cnt | input | 8 | Ch1 hit limit |
| c2_addr_en | input | 1 | Ch2 address field enable |
| c2_use_pc | input | 1 | Ch2 compares PC instead of bus address |
| c2_addr | input | 32 | Ch2 address value |
| c2_rw_en | input | 1 | Ch2 direction field enable |
| c2_rw | input | 2 | Ch2 direction code |
| c2_bus_en | input | 1 | Ch2 bus-type field enable |
| c2_bus | input | 2 | Ch2 bus-type select |
| c2_asid_en | input | 1 | Ch2 ASID field enable |
| c2_asid | input | 8 | Ch2 ASID value |
| c3_io_en | input | 1 | Ch3 internal-I/O event enable |
| c3_tlb_en | input | 1 | Ch3 TLB-load event enable |
| flag_clr | input | 3 | Per-channel flag clear strobes |
| match_flag | output | 3 | Sticky per-channel match flags |
| brk_req | output | 1 | Break request |

## Verification
The bench targets byte-lane masking. A comparator that ignores the size would miss a byte hit whose upper data bytes differ, or it would accept a word access whose second lane disagrees. It counts hits and clears the tally: an off-by-one counter fires on the second or fourth hit instead of the third, and a tally that survives a clear fires early. It drives a clear and a fresh match in the same cycle, which a clear-priority flag would lose. It raises `swbp_exec` alongside an otherwise perfect channel-2 hit, and it checks the DMA and cache-miss cases of the bus-type select, where a wrong decode would accept DMA under the all-CPU select or reject a CPU miss.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_RSV = 2'd3} size_e;
  typedef enum logic [1:0] {SRC_FETCH = 2'd0, SRC_DATA = 2'd1, SRC_DMA = 2'd2, SRC_RSV = 2'd3} src_e;
  typedef enum logic [1:0] {BUS_CPU_ALL = 2'd0, BUS_CPU_DATA = 2'd1, BUS_MISS = 2'd2, BUS_NONE = 2'd3} bus_sel_e;
  localparam int unsigned NCH = 3;
endpackage

// File: rtl/brk_common.sv
module brk_common #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] cyc_addr,
  input  logic [AW-1:0] cyc_pc,
  input  logic          cyc_write,
  input  logic [1:0]    cyc_src,
  input  logic          cyc_cache_hit,
  input  logic          addr_en,
  input  logic          use_pc,
  input  logic [AW-1:0] addr_val,
  input  logic          rw_en,
  input  logic [1:0]    rw_val,
  input  logic          bus_en,
  input  logic [1:0]    bus_val,
  output logic          any_en,
  output logic          fields_ok
);
  import brk_pkg::*;
  logic addr_ok, rw_ok, bus_ok;

  always_comb begin
    addr_ok = ((use_pc ? cyc_pc : cyc_addr) == addr_val);
    rw_ok   = cyc_write ? rw_val[1] : rw_val[0];
    unique case (bus_sel_e'(bus_val))
      BUS_CPU_ALL:  bus_ok = (cyc_src == SRC_FETCH) || (cyc_src == SRC_DATA);
      BUS_CPU_DATA: bus_ok = (cyc_src == SRC_DATA);
      BUS_MISS:     bus_ok = (cyc_src != SRC_RSV) && !cyc_cache_hit;
      default:      bus_ok = 1'b0;
    endcase
    any_en    = addr_en | rw_en | bus_en;
    fields_ok = (!addr_en | addr_ok) & (!rw_en | rw_ok) & (!bus_en | bus_ok);
  end
endmodule

// File: rtl/brk_chan_a.sv
module brk_chan_a #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_valid,
  input  logic [AW-1:0] cyc_addr,
  input  logic [AW-1:0] cyc_pc,
  input  logic [DW-1:0] cyc_data,
  input  logic [1:0]    cyc_size,
  input  logic          cyc_write,
  input  logic [1:0]    cyc_src,
  input  logic          cyc_cache_hit,
  input  logic          addr_en,
  input  logic          use_pc,
  input  logic [AW-1:0] addr_val,
  input  logic          data_en,
  input  logic [DW-1:0] data_val,
  input  logic          size_en,
  input  logic [1:0]    size_val,
  input  logic          rw_en,
  input  logic [1:0]    rw_val,
  input  logic          bus_en,
  input  logic [1:0]    bus_val,
  input  logic          cnt_en,
  input  logic [CW-1:0] cnt_lim,
  input  logic          clr,
  output logic          hit
);
  localparam int unsigned NLANE = DW / 8;

  logic             com_any, com_ok;
  logic [NLANE-1:0] lane_ok;
  logic [3:0]       nbytes;
  logic             data_ok, raw;
  logic [CW-1:0]    cnt_q, cnt_d, lim_eff;
  logic [CW:0]      tally;
  logic             cnt_we;

  brk_common #(.AW(AW)) u_com (
    .cyc_addr(cyc_addr), .cyc_pc(cyc_pc), .cyc_write(cyc_write),
    .cyc_src(cyc_src), .cyc_cache_hit(cyc_cache_hit),
    .addr_en(addr_en), .use_pc(use_pc), .addr_val(addr_val),
    .rw_en(rw_en), .rw_val(rw_val), .bus_en(bus_en), .bus_val(bus_val),
    .any_en(com_any), .fields_ok(com_ok)
  );

  assign nbytes = 4'd1 << cyc_size;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_ok[g] = (g >= int'(nbytes)) || (cyc_data[g*8 +: 8] == data_val[g*8 +: 8]);
  end

  always_comb begin
    data_ok = &lane_ok;
    raw     = cyc_valid & (com_any | data_en | size_en) & com_ok
            & (!data_en | data_ok) & (!size_en | (cyc_size == size_val));
    lim_eff = (cnt_lim == '0) ? CW'(1) : cnt_lim;
    tally   = {1'b0, cnt_q} + 1'b1;
    hit     = raw & (!cnt_en | (tally >= {1'b0, lim_eff}));
    cnt_we  = clr | (raw & cnt_en);
    cnt_d   = (clr | hit) ? '0 : tally[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/brk_chan_b.sv
module brk_chan_b #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 8
) (
  input  logic          cyc_valid,
  input  logic [AW-1:0] cyc_addr,
  input  logic [AW-1:0] cyc_pc,
  input  logic          cyc_write,
  input  logic [1:0]    cyc_src,
  input  logic          cyc_cache_hit,
  input  logic [IW-1:0] cyc_asid,
  input  logic          swbp_exec,
  input  logic          addr_en,
  input  logic          use_pc,
  input  logic [AW-1:0] addr_val,
  input  logic          rw_en,
  input  logic [1:0]    rw_val,
  input  logic          bus_en,
  input  logic [1:0]    bus_val,
  input  logic          asid_en,
  input  logic [IW-1:0] asid_val,
  output logic          hit
);
  logic com_any, com_ok;

  brk_common #(.AW(AW)) u_com (
    .cyc_addr(cyc_addr), .cyc_pc(cyc_pc), .cyc_write(cyc_write),
    .cyc_src(cyc_src), .cyc_cache_hit(cyc_cache_hit),
    .addr_en(addr_en), .use_pc(use_pc), .addr_val(addr_val),
    .rw_en(rw_en), .rw_val(rw_val), .bus_en(bus_en), .bus_val(bus_val),
    .any_en(com_any), .fields_ok(com_ok)
  );

  always_comb begin
    hit = cyc_valid & !swbp_exec & (com_any | asid_en) & com_ok
        & (!asid_en | (cyc_asid == asid_val));
  end
endmodule

// File: rtl/brk_chan_c.sv
module brk_chan_c (
  input  logic cyc_valid,
  input  logic cyc_io,
  input  logic cyc_tlbld,
  input  logic io_en,
  input  logic tlb_en,
  output logic hit
);
  always_comb begin
    hit = cyc_valid & (io_en | tlb_en) & (!io_en | cyc_io) & (!tlb_en | cyc_tlbld);
  end
endmodule

// File: rtl/brk_cond_top.sv
module brk_cond_top #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_valid,
  input  logic [AW-1:0] cyc_addr,
  input  logic [AW-1:0] cyc_pc,
  input  logic [DW-1:0] cyc_data,
  input  logic [1:0]    cyc_size,
  input  logic          cyc_write,
  input  logic [1:0]    cyc_src,
  input  logic          cyc_cache_hit,
  input  logic [IW-1:0] cyc_asid,
  input  logic          cyc_io,
  input  logic          cyc_tlbld,
  input  logic          swbp_exec,
  input  logic          c1_addr_en,
  input  logic          c1_use_pc,
  input  logic [AW-1:0] c1_addr,
  input  logic          c1_data_en,
  input  logic [DW-1:0] c1_data,
  input  logic          c1_size_en,
  input  logic [1:0]    c1_size,
  input  logic          c1_rw_en,
  input  logic [1:0]    c1_rw,
  input  logic          c1_bus_en,
  input  logic [1:0]    c1_bus,
  input  logic          c1_cnt_en,
  input  logic [CW-1:0] c1_cnt,
  input  logic          c2_addr_en,
  input  logic          c2_use_pc,
  input  logic [AW-1:0] c2_addr,
  input  logic          c2_rw_en,
  input  logic [1:0]    c2_rw,
  input  logic          c2_bus_en,
  input  logic [1:0]    c2_bus,
  input  logic          c2_asid_en,
  input  logic [IW-1:0] c2_asid,
  input  logic          c3_io_en,
  input  logic          c3_tlb_en,
  input  logic [2:0]    flag_clr,
  output logic [2:0]    match_flag,
  output logic          brk_req
);
  import brk_pkg::*;

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [NCH-1:0] hit, flag_q, flag_d;
  logic           flag_we, ev_q, ev_d, brk_q, brk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  brk_chan_a #(.AW(AW), .DW(DW), .CW(CW)) u_ch1 (
    .clk(clk), .rst_n(rst_int_n), .cyc_valid(cyc_valid),
    .cyc_addr(cyc_addr), .cyc_pc(cyc_pc), .cyc_data(cyc_data),
    .cyc_size(cyc_size), .cyc_write(cyc_write), .cyc_src(cyc_src),
    .cyc_cache_hit(cyc_cache_hit),
    .addr_en(c1_addr_en), .use_pc(c1_use_pc), .addr_val(c1_addr),
    .data_en(c1_data_en), .data_val(c1_data),
    .size_en(c1_size_en), .size_val(c1_size),
    .rw_en(c1_rw_en), .rw_val(c1_rw), .bus_en(c1_bus_en), .bus_val(c1_bus),
    .cnt_en(c1_cnt_en), .cnt_lim(c1_cnt), .clr(flag_clr[0]), .hit(hit[0])
  );

  brk_chan_b #(.AW(AW), .IW(IW)) u_ch2 (
    .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_pc(cyc_pc),
    .cyc_write(cyc_write), .cyc_src(cyc_src), .cyc_cache_hit(cyc_cache_hit),
    .cyc_asid(cyc_asid), .swbp_exec(swbp_exec),
    .addr_en(c2_addr_en), .use_pc(c2_use_pc), .addr_val(c2_addr),
    .rw_en(c2_rw_en), .rw_val(c2_rw), .bus_en(c2_bus_en), .bus_val(c2_bus),
    .asid_en(c2_asid_en), .asid_val(c2_asid), .hit(hit[1])
  );

  brk_chan_c u_ch3 (
    .cyc_valid(cyc_valid), .cyc_io(cyc_io), .cyc_tlbld(cyc_tlbld),
    .io_en(c3_io_en), .tlb_en(c3_tlb_en), .hit(hit[2])
  );

  always_comb begin
    flag_d  = (flag_q & ~flag_clr) | hit;
    flag_we = |(flag_clr | hit);
    ev_d    = |hit;
    brk_d   = ev_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flag_q <= '0;
      ev_q   <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      if (flag_we) flag_q <= flag_d;
      ev_q  <= ev_d;
      brk_q <= brk_d;
    end
  end

  assign match_flag = flag_q;
  assign brk_req    = brk_q;
endmodule

// File: rtl/brk_cond_chk.sv
module brk_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_valid,
  input logic       cyc_io,
  input logic       cyc_tlbld,
  input logic       swbp_exec,
  input logic [2:0] flag_clr,
  input logic [2:0] match_flag,
  input logic       brk_req
);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(match_flag) & ~$past(flag_clr) & ~match_flag) == 3'b000));

  // R10
  flag_rise_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag != 3'b000 && $past(match_flag) == 3'b000) |=> brk_req);

  // R10
  brk_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> ($past(match_flag) != 3'b000));

  // R7
  swbp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swbp_exec && !match_flag[1]) |=> !match_flag[1]);

  // R5
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_valid && match_flag == 3'b000) |=> (match_flag == 3'b000));

  // R8
  ch3_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_io && !cyc_tlbld && !match_flag[2]) |=> !match_flag[2]);
endmodule

bind brk_cond_top brk_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_io(cyc_io),
  .cyc_tlbld(cyc_tlbld), .swbp_exec(swbp_exec), .flag_clr(flag_clr),
  .match_flag(match_flag), .brk_req(brk_req)
);

// File: tb/brk_cond_top_bench.sv
module brk_cond_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_valid;
  logic [31:0] cyc_addr, cyc_pc, cyc_data;
  logic [1:0]  cyc_size;
  logic        cyc_write;
  logic [1:0]  cyc_src;
  logic        cyc_cache_hit;
  logic [7:0]  cyc_asid;
  logic        cyc_io, cyc_tlbld, swbp_exec;
  logic        c1_addr_en, c1_use_pc, c1_data_en, c1_size_en, c1_rw_en, c1_bus_en, c1_cnt_en;
  logic [31:0] c1_addr, c1_data;
  logic [1:0]  c1_size, c1_rw, c1_bus;
  logic [7:0]  c1_cnt;
  logic        c2_addr_en, c2_use_pc, c2_rw_en, c2_bus_en, c2_asid_en;
  logic [31:0] c2_addr;
  logic [1:0]  c2_rw, c2_bus;
  logic [7:0]  c2_asid;
  logic        c3_io_en, c3_tlb_en;
  logic [2:0]  flag_clr;
  logic [2:0]  match_flag;
  logic        brk_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  brk_cond_top u_brk_cond_top (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] pc;
    logic [31:0] data;
    logic [1:0]  size;
    logic        wr;
    logic [1:0]  src;
    logic        hit;
    logic [7:0]  asid;
    logic        io;
    logic        swbp;
    logic [2:0]  exp;
  } vec_t;

  localparam int NV = 13;
  // Fixed table setup: ch1 addr 0x1000 + data 0xAB + rw either + bus all-CPU,
  // ch2 pc 0x2000 + write only + CPU data + asid 5, ch3 internal I/O only.
  localparam vec_t TBL [NV] = '{
    '{32'h1000, 32'h0,    32'h123456AB, 2'd0, 1'b0, 2'd1, 1'b1, 8'd0, 1'b0, 1'b0, 3'b001}, // R2 byte lane
    '{32'h1000, 32'h0,    32'h123456AB, 2'd2, 1'b0, 2'd1, 1'b1, 8'd0, 1'b0, 1'b0, 3'b000}, // R2 long mismatch
    '{32'h1000, 32'h0,    32'h000000AB, 2'd2, 1'b0, 2'd0, 1'b1, 8'd0, 1'b0, 1'b0, 3'b001}, // R1 R4 fetch
    '{32'h1000, 32'h0,    32'h000000AB, 2'd0, 1'b0, 2'd2, 1'b0, 8'd0, 1'b0, 1'b0, 3'b000}, // R4 DMA excluded
    '{32'h0,    32'h2000, 32'h0,        2'd2, 1'b1, 2'd1, 1'b0, 8'd5, 1'b0, 1'b0, 3'b010}, // R1 R7 ch2
    '{32'h0,    32'h2000, 32'h0,        2'd2, 1'b0, 2'd1, 1'b0, 8'd5, 1'b0, 1'b0, 3'b000}, // R3 read rejected
    '{32'h0,    32'h2000, 32'h0,        2'd2, 1'b1, 2'd1, 1'b0, 8'd6, 1'b0, 1'b0, 3'b000}, // R7 asid
    '{32'h0,    32'h2000, 32'h0,        2'd2, 1'b1, 2'd1, 1'b0, 8'd5, 1'b0, 1'b1, 3'b000}, // R7 swbp
    '{32'h0,    32'h2000, 32'h0,        2'd2, 1'b1, 2'd0, 1'b0, 8'd5, 1'b0, 1'b0, 3'b000}, // R4 data-only
    '{32'h0,    32'h0,    32'h0,        2'd0, 1'b0, 2'd0, 1'b0, 8'd0, 1'b1, 1'b0, 3'b100}, // R8 io
    '{32'h1000, 32'h2000, 32'h123456AB, 2'd0, 1'b1, 2'd1, 1'b1, 8'd5, 1'b1, 1'b0, 3'b111}, // R5 all
    '{32'h1000, 32'h0,    32'h000000AB, 2'd1, 1'b0, 2'd0, 1'b0, 8'd0, 1'b0, 1'b0, 3'b001}, // R2 word
    '{32'h1000, 32'h0,    32'h001201AB, 2'd1, 1'b0, 2'd0, 1'b0, 8'd0, 1'b0, 1'b0, 3'b000}  // R2 word lane1
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cyc_valid = 0; cyc_addr = 0; cyc_pc = 0; cyc_data = 0; cyc_size = 0;
    cyc_write = 0; cyc_src = 0; cyc_cache_hit = 0; cyc_asid = 0;
    cyc_io = 0; cyc_tlbld = 0; swbp_exec = 0; flag_clr = 0;
  endtask

  task automatic cfg_off();
    c1_addr_en = 0; c1_use_pc = 0; c1_addr = 0; c1_data_en = 0; c1_data = 0;
    c1_size_en = 0; c1_size = 0; c1_rw_en = 0; c1_rw = 0; c1_bus_en = 0;
    c1_bus = 0; c1_cnt_en = 0; c1_cnt = 0;
    c2_addr_en = 0; c2_use_pc = 0; c2_addr = 0; c2_rw_en = 0; c2_rw = 0;
    c2_bus_en = 0; c2_bus = 0; c2_asid_en = 0; c2_asid = 0;
    c3_io_en = 0; c3_tlb_en = 0;
  endtask

  task automatic clear_all();
    idle();
    flag_clr = 3'b111;
    tick();
    flag_clr = 3'b000;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle();
    cfg_off();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();
    // R11 reset state
    chk("R11 flags after reset", 32'(match_flag), 0);
    chk("R11 brk after reset", 32'(brk_req), 0);

    // Table walk
    c1_addr_en = 1; c1_addr = 32'h1000; c1_data_en = 1; c1_data = 32'h000000AB;
    c1_rw_en = 1; c1_rw = 2'b11; c1_bus_en = 1; c1_bus = 2'd0;
    c2_addr_en = 1; c2_use_pc = 1; c2_addr = 32'h2000; c2_rw_en = 1; c2_rw = 2'b10;
    c2_bus_en = 1; c2_bus = 2'd1; c2_asid_en = 1; c2_asid = 8'd5;
    c3_io_en = 1;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      clear_all();
      cyc_valid = 1; cyc_addr = v.addr; cyc_pc = v.pc; cyc_data = v.data;
      cyc_size = v.size; cyc_write = v.wr; cyc_src = v.src; cyc_cache_hit = v.hit;
      cyc_asid = v.asid; cyc_io = v.io; swbp_exec = v.swbp;
      tick();
      chk($sformatf("R5 table vector %0d flags", i), 32'(match_flag), 32'(v.exp));
      idle();
      tick();
      chk($sformatf("R10 table vector %0d brk", i), 32'(brk_req), 32'(v.exp != 0));
    end

    // R6 count of three
    cfg_off();
    c1_addr_en = 1; c1_addr = 32'h1000; c1_cnt_en = 1; c1_cnt = 8'd3;
    clear_all();
    for (int k = 1; k <= 3; k++) begin
      idle(); cyc_valid = 1; cyc_addr = 32'h1000;
      tick();
      chk($sformatf("R6 hit %0d of 3", k), 32'(match_flag[0]), 32'(k == 3));
    end
    idle();
    tick();
    chk("R10 brk after counted hit", 32'(brk_req), 1);
    // R6 tally restarts after clear: two hits, no flag
    clear_all();
    for (int k = 1; k <= 2; k++) begin
      idle(); cyc_valid = 1; cyc_addr = 32'h1000;
      tick();
    end
    chk("R6 tally restarted", 32'(match_flag[0]), 0);
    // R6 partial tally cleared by clear strobe
    clear_all();
    for (int k = 1; k <= 2; k++) begin
      idle(); cyc_valid = 1; cyc_addr = 32'h1000;
      tick();
    end
    chk("R6 partial count before clear", 32'(match_flag[0]), 0);
    clear_all();
    idle(); cyc_valid = 1; cyc_addr = 32'h1000;
    tick();
    chk("R6 clear resets tally", 32'(match_flag[0]), 0);
    // R6 limit 0 acts as 1
    c1_cnt = 8'd0;
    clear_all();
    idle(); cyc_valid = 1; cyc_addr = 32'h1000;
    tick();
    chk("R6 limit zero fires at once", 32'(match_flag[0]), 1);

    // R1 PC select on channel 1
    cfg_off();
    c1_addr_en = 1; c1_use_pc = 1; c1_addr = 32'h3000;
    clear_all();
    idle(); cyc_valid = 1; cyc_addr = 32'h1234; cyc_pc = 32'h3000;
    tick();
    chk("R1 pc select match", 32'(match_flag), 3'b001);

    // R2 size restriction: word only
    cfg_off();
    c1_data_en = 1; c1_data = 32'h000000AB; c1_size_en = 1; c1_size = 2'd1;
    clear_all();
    idle(); cyc_valid = 1; cyc_data = 32'hFFFF00AB; cyc_size = 2'd0;
    tick();
    chk("R2 size restriction rejects byte", 32'(match_flag), 0);
    idle(); cyc_valid = 1; cyc_data = 32'hFFFF00AB; cyc_size = 2'd1;
    tick();
    chk("R2 size restriction accepts word", 32'(match_flag), 3'b001);

    // R4 miss select
    cfg_off();
    c2_bus_en = 1; c2_bus = 2'd2;
    clear_all();
    idle(); cyc_valid = 1; cyc_src = 2'd0; cyc_cache_hit = 1;
    tick();
    chk("R4 miss select rejects hit", 32'(match_flag), 0);
    idle(); cyc_valid = 1; cyc_src = 2'd2; cyc_cache_hit = 0;
    tick();
    chk("R4 miss select accepts DMA", 32'(match_flag), 3'b010);
    clear_all();
    idle(); cyc_valid = 1; cyc_src = 2'd1; cyc_cache_hit = 0;
    tick();
    chk("R4 miss select accepts CPU miss", 32'(match_flag), 3'b010);

    // R3 direction code 00 never matches
    cfg_off();
    c2_rw_en = 1; c2_rw = 2'b00;
    clear_all();
    idle(); cyc_valid = 1; cyc_write = 1;
    tick();
    idle(); cyc_valid = 1; cyc_write = 0;
    tick();
    chk("R3 direction none", 32'(match_flag), 0);

    // R8 both events required
    cfg_off();
    c3_io_en = 1; c3_tlb_en = 1;
    clear_all();
    idle(); cyc_valid = 1; cyc_io = 1;
    tick();
    chk("R8 io alone with both enabled", 32'(match_flag), 0);
    idle(); cyc_valid = 1; cyc_io = 1; cyc_tlbld = 1;
    tick();
    chk("R8 io and tlb", 32'(match_flag), 3'b100);
    c3_io_en = 0;
    clear_all();
    idle(); cyc_valid = 1; cyc_tlbld = 1;
    tick();
    chk("R8 tlb only", 32'(match_flag), 3'b100);

    // R5 invalid cycle and no enabled field
    cfg_off();
    c3_io_en = 1;
    clear_all();
    idle(); cyc_io = 1;
    tick();
    chk("R5 invalid cycle ignored", 32'(match_flag), 0);
    c3_io_en = 0;
    idle(); cyc_valid = 1; cyc_io = 1; cyc_tlbld = 1;
    tick();
    chk("R5 no field enabled", 32'(match_flag), 0);

    // R9 sticky, set beats clear
    c3_io_en = 1;
    idle(); cyc_valid = 1; cyc_io = 1;
    tick();
    idle();
    repeat (3) tick();
    chk("R9 flag holds", 32'(match_flag), 3'b100);
    chk("R10 brk drops after pulse", 32'(brk_req), 0);
    idle(); cyc_valid = 1; cyc_io = 1; flag_clr = 3'b100;
    tick();
    chk("R9 set wins over clear", 32'(match_flag), 3'b100);
    idle(); flag_clr = 3'b100;
    tick();
    chk("R9 clear", 32'(match_flag), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule